// File: doc/BRIEF.md
# Vector Rounding Narrowing Shifter

The block takes a vector of 32-bit lanes and a small shift immediate. Each lane is shifted right with round-half-up: half the weight of the bits being dropped is added first, then the sum is shifted. The low 16 bits of every shifted lane go into the bottom 16-bit slot of that same 32-bit lane position in the result. The upper 16-bit slot of every lane position is always cleared. No saturation is applied.

The vector width is a parameter. It must be a multiple of 128 bits, from 128 to 2048. A signedness flag selects whether the lanes are read as signed or unsigned. An immediate outside 1..16 raises an error flag and zeroes the whole result for that operation.

By default the datapath is registered, with one cycle of latency. The output keeps its value in any cycle without a valid input. A parameter can select a purely combinational variant instead. A second parameter selects how the rounding is built: either add-then-shift, or truncate-then-increment.

Top module: `vrns_top`

## Requirements
- R1: For lane i (source bits 32i+31:32i), output bits 32i+15:32i equal the low 16 bits of (x + 2^(sh-1)) >> sh, computed exactly, when sh is in 1..16.
- R2: Output bits 32i+31:32i+16 are zero for every lane i in every result.
- R3: There is no saturation. A shifted value that does not fit in 16 bits keeps only its low 16 bits; for example, 0x7FFFFFFF with sh=1 gives 0x0000.
- R4: The signed flag (1 = signed, 0 = unsigned) never changes the output bits for the same operand and shift.
- R5: A valid operation with sh equal to 0 or 17..31 gives out_err=1 and an all-zero out_vec. A valid operation with sh in 1..16 gives out_err=0.
- R6: out_valid equals in_valid delayed by one clock.
- R7: In a cycle with in_valid=0, out_vec and out_err keep their previous values on the next clock, whatever the other inputs are.
- R8: While rst_n is low at a clock edge, out_valid, out_err and out_vec all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_vec | input | VEC_W | Source vector of 32-bit lanes |
| in_shift | input | 5 | Shift immediate; legal range 1..16 |
| in_signed | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| out_valid | output | 1 | Result strobe |
| out_vec | output | VEC_W | Narrowed result; upper half of each lane is zero |
| out_err | output | 1 | Illegal shift immediate in the captured operation |

## Verification
The hardest cases to reach are the ones where the rounding carry travels a long way. Examples are lanes one below or exactly at a rounding midpoint, where a single bit decides the increment. Another is the wrap past bit 31 for 0x7FFFFFFF and all-ones, where signed and unsigned readings differ only above the kept bits. The stimulus builds these lanes directly: for each shift it loads values of the form k·2^sh + 2^(sh-1) and that value minus one, with k positive and negative. It then issues every such vector under both signedness settings, so the flag's lack of effect is observed on operands where it could matter.

// File: rtl/vrns_pkg.sv
// Shared sizes for the vector rounding narrowing shifter.
// Assumes 32-bit source lanes narrowed to 16-bit results.
package vrns_pkg;
    localparam int LANE_W    = 32;
    localparam int HALF_W    = LANE_W / 2;
    localparam int SH_W      = 5;
    localparam int SH_MIN    = 1;
    localparam int SH_MAX    = 16;

    // Rounding construction choice for a lane.
    typedef enum logic [0:0] {
        RND_ADD_FIRST = 1'b0,
        RND_TRUNC_INC = 1'b1
    } rnd_style_e;
endpackage

// File: rtl/vrns_shift_chk.sv
// Range check of the shift immediate.
// Assumes the immediate is unsigned; legal means SH_MIN <= sh <= SH_MAX.
module vrns_shift_chk
    import vrns_pkg::*;
#(
    parameter int MIN_SH = SH_MIN,
    parameter int MAX_SH = SH_MAX
) (
    input  logic [SH_W-1:0] sh,
    output logic            legal
);
    // Compare the immediate against both bounds.
    always_comb begin
        legal = (int'(sh) >= MIN_SH) && (int'(sh) <= MAX_SH);
    end
endmodule

// File: rtl/vrns_lane.sv
// One lane: rounding right shift of a 32-bit value, narrowed to 16 bits.
// Assumes 1 <= sh <= 16; for other values the result is don't-care
// (the top level masks it). STYLE picks how the rounding is built.
module vrns_lane
    import vrns_pkg::*;
#(
    parameter rnd_style_e STYLE = RND_ADD_FIRST
) (
    input  logic [LANE_W-1:0] x,
    input  logic [SH_W-1:0]   sh,
    input  logic              is_signed,
    output logic [HALF_W-1:0] y
);
    logic [SH_W-1:0] sh_m1;

    // Position of the most significant discarded bit.
    always_comb sh_m1 = sh - SH_W'(1);

    generate
        if (STYLE == RND_ADD_FIRST) begin : g_add_first
            logic [LANE_W-1:0] rnd_k;
            logic [LANE_W-1:0] sum;
            logic [LANE_W-1:0] shifted;

            // Add half the dropped weight with 32-bit wrap, then shift.
            always_comb begin
                rnd_k = LANE_W'(1) << sh_m1;
                sum   = x + rnd_k;
                if (is_signed)
                    shifted = LANE_W'($signed(sum) >>> sh);
                else
                    shifted = sum >> sh;
                y = shifted[HALF_W-1:0];
            end
        end else begin : g_trunc_inc
            logic [LANE_W-1:0] trunc;
            logic [LANE_W-1:0] drop;
            logic              inc;

            // Shift first, then add the top discarded bit.
            always_comb begin
                if (is_signed)
                    trunc = LANE_W'($signed(x) >>> sh);
                else
                    trunc = x >> sh;
                drop = x >> sh_m1;
                inc  = drop[0];
                y    = trunc[HALF_W-1:0] + HALF_W'(inc);
            end
        end
    endgenerate
endmodule

// File: rtl/vrns_out_reg.sv
// Output stage: one register of latency, or a plain pass-through.
// Assumes data is captured only on a valid cycle and held otherwise.
module vrns_out_reg #(
    parameter int DW         = 128,
    parameter bit REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_valid,
    input  logic [DW-1:0] d_data,
    input  logic          d_err,
    input  logic [4:0]    d_shift,
    output logic          q_valid,
    output logic [DW-1:0] q_data,
    output logic          q_err
);
    generate
        if (REGISTERED) begin : g_reg
            // Track the strobe every cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) q_valid <= 1'b0;
                else        q_valid <= d_valid;
            end

            // Capture data and error only on a valid cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_data <= '0;
                    q_err  <= 1'b0;
                end else if (d_valid) begin
                    q_data <= d_data;
                    q_err  <= d_err;
                end
            end

            p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
                d_valid |=> q_valid);
            p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !d_valid |=> !q_valid);
            p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !d_valid |=> ($stable(q_data) && $stable(q_err)));
            p_err_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (d_valid && ((d_shift == 5'd0) || (d_shift > 5'd16))) |=> q_err);
            p_ok_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (d_valid && (d_shift != 5'd0) && (d_shift <= 5'd16)) |=> !q_err);
        end else begin : g_comb
            // Pass the operation straight through.
            always_comb begin
                q_valid = d_valid;
                q_data  = d_data;
                q_err   = d_err;
            end
        end
    endgenerate
endmodule

// File: rtl/vrns_top.sv
// Vector rounding narrowing shifter, top level.
// Assumes VEC_W is a multiple of 128 between 128 and 2048. Each 32-bit
// lane is rounded and shifted into its low half; its high half is zeroed.
// An illegal immediate zeroes the whole result and raises out_err.
module vrns_top
    import vrns_pkg::*;
#(
    parameter int         VEC_W      = 512,
    parameter bit         REGISTERED = 1'b1,
    parameter rnd_style_e STYLE      = RND_ADD_FIRST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic [SH_W-1:0]  in_shift,
    input  logic             in_signed,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_err
);
    localparam int N_LANES = VEC_W / LANE_W;

    logic             sh_legal;
    logic [VEC_W-1:0] nar_vec;
    logic [VEC_W-1:0] res_vec;

    vrns_shift_chk u_chk (
        .sh    (in_shift),
        .legal (sh_legal)
    );

    genvar li;
    generate
        for (li = 0; li < N_LANES; li++) begin : g_lane
            logic [HALF_W-1:0] lane_y;

            vrns_lane #(.STYLE(STYLE)) u_lane (
                .x         (in_vec[li*LANE_W +: LANE_W]),
                .sh        (in_shift),
                .is_signed (in_signed),
                .y         (lane_y)
            );

            // Place the narrowed value low and clear the high half.
            always_comb begin
                nar_vec[li*LANE_W +: LANE_W] = {{HALF_W{1'b0}}, lane_y};
            end

            p_odd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
                out_vec[li*LANE_W+HALF_W +: HALF_W] == '0);
        end
    endgenerate

    // Mask the whole result when the immediate is out of range.
    always_comb res_vec = sh_legal ? nar_vec : '0;

    vrns_out_reg #(.DW(VEC_W), .REGISTERED(REGISTERED)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_data  (res_vec),
        .d_err   (!sh_legal),
        .d_shift (in_shift),
        .q_valid (out_valid),
        .q_data  (out_vec),
        .q_err   (out_err)
    );

    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_vec == '0));
endmodule

// File: tb/vrns_top_bench.sv
`timescale 1ns/100ps
module vrns_top_bench;
    localparam int VW = 512;
    localparam int NL = VW / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic [4:0]    in_shift = 5'd1;
    logic          in_signed = 1'b0;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic          out_err;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    vrns_top #(.VEC_W(VW)) u_vrns_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_shift(in_shift), .in_signed(in_signed),
        .out_valid(out_valid), .out_vec(out_vec), .out_err(out_err)
    );

    // Exact 64-bit reference for one lane.
    function automatic logic [15:0] ref_lane(logic [31:0] x, int sh, bit sgn);
        longint v;
        v = sgn ? longint'($signed(x)) : longint'({32'd0, x});
        v = v + (longint'(1) <<< (sh - 1));
        v = v >>> sh;
        return v[15:0];
    endfunction

    logic [VW-1:0] exp_vec = '0;
    logic          exp_valid = 1'b0;
    logic          exp_err = 1'b0;

    // Behavioural model updated at each clock.
    always @(posedge clk) begin
        logic [VW-1:0] t;
        if (!rst_n) begin
            exp_vec <= '0; exp_valid <= 1'b0; exp_err <= 1'b0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                t = '0;
                if (in_shift >= 5'd1 && in_shift <= 5'd16) begin
                    for (int i = 0; i < NL; i++)
                        t[i*32 +: 16] = ref_lane(in_vec[i*32 +: 32], int'(in_shift), in_signed);
                    exp_err <= 1'b0;
                end else begin
                    exp_err <= 1'b1;
                end
                exp_vec <= t;
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        bit bad;
        if (rst_n && !done) begin
            bad = 1'b0;
            checks++;
            if (out_valid !== exp_valid) begin
                $display("FAIL R6 out_valid act=%0b exp=%0b", out_valid, exp_valid); bad = 1'b1;
            end
            if (out_err !== exp_err) begin
                $display("FAIL R5 out_err act=%0b exp=%0b", out_err, exp_err); bad = 1'b1;
            end
            for (int i = 0; i < NL; i++) begin
                if (out_vec[i*32 +: 16] !== exp_vec[i*32 +: 16]) begin
                    $display("FAIL %s lane %0d act=%h exp=%h", cur_req, i,
                             out_vec[i*32 +: 16], exp_vec[i*32 +: 16]); bad = 1'b1;
                end
                if (out_vec[i*32+16 +: 16] !== 16'h0) begin
                    $display("FAIL R2 lane %0d high act=%h exp=0000", i, out_vec[i*32+16 +: 16]);
                    bad = 1'b1;
                end
            end
            if (bad) errors++;
        end
    end

    task automatic drive(logic [VW-1:0] v, int sh, bit sgn, bit vld);
        @(posedge clk); #1;
        in_vec = v; in_shift = 5'(sh); in_signed = sgn; in_valid = vld;
    endtask

    function automatic logic [VW-1:0] fill(logic [31:0] a, logic [31:0] b);
        logic [VW-1:0] v;
        for (int i = 0; i < NL; i++) v[i*32 +: 32] = (i % 2 == 0) ? a : b;
        return v;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < NL; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Watchdog: a hung run is a failure.
    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] mid;
        logic [VW-1:0] a_out;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R8 reset act=%0b/%0b/%h exp=0/0/0", out_valid, out_err, out_vec);
        end
        rst_n = 1'b1;

        // R1 boundary values at every shift, both signedness settings.
        cur_req = "R1";
        for (int sh = 1; sh <= 16; sh++) begin
            for (int s = 0; s < 2; s++) begin
                drive(fill(32'h0, 32'hFFFFFFFF), sh, s[0], 1'b1);
                drive(fill(32'h7FFFFFFF, 32'h80000000), sh, s[0], 1'b1);
            end
        end

        // R1 rounding midpoints and just below them.
        for (int sh = 1; sh <= 16; sh++) begin
            for (int i = 0; i < NL; i++) begin
                int k = (i - NL/2) * 37 + 5;
                logic [31:0] m = 32'(k * (1 << sh) + (1 << (sh - 1)));
                mid[i*32 +: 32] = (i % 2 == 0) ? m : m - 32'd1;
            end
            drive(mid, sh, 1'b0, 1'b1);
            drive(mid, sh, 1'b1, 1'b1);
        end

        // R3 wrap without saturation.
        cur_req = "R3";
        drive(fill(32'h7FFFFFFF, 32'h12345678), 1, 1'b0, 1'b1);
        drive(fill(32'hFFFF8000, 32'h00FFFFFF), 1, 1'b1, 1'b1);
        drive(fill(32'h7FFFFFFF, 32'h80000000), 2, 1'b1, 1'b1);

        // R4 signed flag does not alter the result.
        cur_req = "R4";
        for (int n = 0; n < 6; n++) begin
            logic [VW-1:0] v = (n == 0) ? fill(32'hFFFFFFFF, 32'h80000000) : rnd_vec();
            int sh = (n * 3) % 16 + 1;
            drive(v, sh, 1'b0, 1'b1);
            @(posedge clk); @(negedge clk);
            a_out = out_vec;
            drive(v, sh, 1'b1, 1'b1);
            @(posedge clk); @(negedge clk);
            checks++;
            if (out_vec !== a_out) begin
                errors++;
                $display("FAIL R4 sh=%0d act=%h exp=%h", sh, out_vec, a_out);
            end
        end

        // R5 illegal immediates, then a legal one clears the error.
        cur_req = "R5";
        drive(rnd_vec(), 0, 1'b0, 1'b1);
        drive(rnd_vec(), 17, 1'b1, 1'b1);
        drive(rnd_vec(), 31, 1'b0, 1'b1);
        drive(rnd_vec(), 16, 1'b0, 1'b1);

        // R7 idle cycles with junk inputs must hold.
        cur_req = "R7";
        for (int n = 0; n < 8; n++) drive(rnd_vec(), n * 4, n[0], 1'b0);

        // R6 mixed strobe with random data.
        cur_req = "R6";
        for (int n = 0; n < 300; n++)
            drive(rnd_vec(), ($urandom % 16) + 1, $urandom % 2, ($urandom % 3) != 0);
        drive('0, 1, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);

        // R8 reset clears state mid-run.
        done = 1'b1;
        drive(fill(32'h12345678, 32'h9ABCDEF0), 1, 1'b0, 1'b1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R8 mid reset act=%0b/%0b/%h exp=0/0/0", out_valid, out_err, out_vec);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule